// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory, using a single word-read port with a request/acknowledge handshake. A one-cycle `start` captures four values: the virtual address, a process-ID offset, the table base and the domain access register. The walker adds the offset to the address to form the modified address. It then reads one or two descriptors and ends with a one-cycle `done`. At `done` it reports either a physical address with its two access-permission bits, or a fault code. In both cases it also reports the domain the first-level descriptor names and that domain's two-bit access value.

The first-level descriptor can name one of four outcomes:
- a fault, with no second read;
- a 1 MB section, mapped directly;
- a coarse second-level table of 256 entries;
- a fine second-level table of 1024 entries.

The second-level descriptor can name one of four outcomes:
- a fault;
- a 64 KB page;
- a 4 KB page;
- a 1 KB tiny page.

A tiny-page descriptor in a fine table maps 1 KB. The same descriptor in a coarse table is a fault, unless the extension mode is on. In that mode it maps a 4 KB page. The extension mode is chosen per walk by `tiny_ext`, and the parameter `TINY_EXT_EN` can remove it.

The controller has four states: `ST_IDLE`, `ST_L1_READ`, `ST_L2_READ` and `ST_DONE`. Its transitions are:
- `ST_IDLE` to `ST_L1_READ` on `start`.
- `ST_L1_READ` to `ST_DONE` on an acknowledged first-level descriptor of type fault or section.
- `ST_L1_READ` to `ST_L2_READ` on an acknowledged first-level descriptor of type coarse or fine.
- `ST_L2_READ` to `ST_DONE` on acknowledge.
- `ST_DONE` to `ST_IDLE` always.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `mem_req`, `done`, `fault` and `paddr` are all 0.
- R2: The walk uses the modified address, which is (`vaddr` + `pid_offset`) modulo 2^32. It is captured at `start`, so later changes on the inputs have no effect on the walk in progress.
- R3: The first read address is {`ttb`[31:14], modified[31:20], 2'b00}.
- R4: A first-level type of 0 ends the walk after exactly one read, with `fault`=1 and `fault_code`=4'h5.
- R5: A first-level type of 2 ends the walk after one read. It reports `paddr` = {desc[31:20], modified[19:0]} and `ap` = desc[11:10].
- R6: `walk_domain` is first-level desc[8:5], and `dom_access` is `dacr`[2·domain+1 : 2·domain]. Both are reported on every completed walk.
- R7: For first-level type 1 (coarse), the second read address is {desc[31:10], modified[19:12], 2'b00}. For type 3 (fine), it is {desc[31:12], modified[19:10], 2'b00}.
- R8: A second-level type of 0 gives `fault`=1 with `fault_code`=4'h7.
- R9: Second-level type 1 gives {desc[31:16], modified[15:0]}, and type 2 gives {desc[31:12], modified[11:0]}. For every non-faulting second-level result, `ap` = desc[5:4].
- R10: Second-level type 3 in a fine table gives {desc[31:10], modified[9:0]}, whatever the value of `tiny_ext`.
- R11: Second-level type 3 in a coarse table gives `fault_code`=4'h7 when `tiny_ext`=0. When `tiny_ext`=1 (with `TINY_EXT_EN`=1), it gives {desc[31:12], modified[11:0]}.
- R12: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`, and only one read is outstanding at a time.
- R13: `done` lasts exactly one cycle and is followed by idle. A `start` seen while a walk is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled in idle only) |
| vaddr | input | 32 | Virtual address |
| pid_offset | input | 32 | Process-ID offset added to vaddr |
| ttb | input | 32 | Translation table base (bits 31:14 used) |
| dacr | input | 32 | Domain access values, 2 bits per domain |
| tiny_ext | input | 1 | Extension mode for tiny pages in coarse tables |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Walk complete (one cycle) |
| paddr | output | 32 | Physical address |
| ap | output | 2 | Access-permission bits |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 4 | 4'h5 section fault, 4'h7 page fault |
| walk_domain | output | 4 | Domain from the first-level descriptor |
| dom_access | output | 2 | Access value of that domain |

## Verification
The bench builds the walker with its defaults: 32-bit addresses and `TINY_EXT_EN`=1. With the extension compiled in, both outcomes of a tiny page found in a coarse table can be reached by switching `tiny_ext`. The bench also checks that a tiny page in a fine table ignores the mode. The memory model acknowledges after 0 to 6 wait cycles. This exercises the request-hold behaviour across long waits, and a stray `start` arriving in the middle of a walk.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

    localparam int VA_W       = 32;
    localparam int DESC_W     = 32;
    localparam int DOM_W      = 4;
    localparam int AP_W       = 2;
    localparam int CODE_W     = 4;

    // Field boundaries inside addresses and descriptors.
    localparam int TTB_LSB    = 14;
    localparam int L1_IDX_LSB = 20;
    localparam int COARSE_LSB = 10;
    localparam int FINE_LSB   = 12;
    localparam int LARGE_LSB  = 16;
    localparam int SMALL_LSB  = 12;
    localparam int TINY_LSB   = 10;
    localparam int L1_AP_LSB  = 10;
    localparam int L2_AP_LSB  = 4;
    localparam int DOM_LSB    = 5;

    localparam logic [CODE_W-1:0] FLT_NONE    = 4'h0;
    localparam logic [CODE_W-1:0] FLT_SECTION = 4'h5;
    localparam logic [CODE_W-1:0] FLT_PAGE    = 4'h7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L1_READ,
        ST_L2_READ,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_COARSE  = 2'd1,
        L1_SECTION = 2'd2,
        L1_FINE    = 2'd3
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'd0,
        L2_LARGE = 2'd1,
        L2_SMALL = 2'd2,
        L2_TINY  = 2'd3
    } l2_kind_e;

    typedef struct packed {
        logic [VA_W-1:0]   paddr;
        logic [AP_W-1:0]   ap;
        logic              fault;
        logic [CODE_W-1:0] code;
    } walk_res_t;

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
    import xlat_walker_pkg::*;
(
    input  logic [VA_W-1:TINY_LSB]   mva_hi,
    input  logic [VA_W-1:TTB_LSB]    ttb_hi,
    input  logic [VA_W-1:COARSE_LSB] tbl_hi,
    input  logic                     fine,
    output logic [VA_W-1:0]          l1_addr,
    output logic [VA_W-1:0]          l2_addr
);

    logic [VA_W-1:0] coarse_addr;
    logic [VA_W-1:0] fine_addr;

    // Word index of the first-level entry: one entry per megabyte.
    assign l1_addr     = {ttb_hi, mva_hi[VA_W-1:L1_IDX_LSB], 2'b00};

    // Coarse tables index by 4 KB, fine tables by 1 KB.
    assign coarse_addr = {tbl_hi, mva_hi[L1_IDX_LSB-1:SMALL_LSB], 2'b00};
    assign fine_addr   = {tbl_hi[VA_W-1:FINE_LSB], mva_hi[L1_IDX_LSB-1:TINY_LSB], 2'b00};

    assign l2_addr     = fine ? fine_addr : coarse_addr;

endmodule

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
    import xlat_walker_pkg::*;
(
    input  logic [DESC_W-1:0]     desc,
    input  logic [L1_IDX_LSB-1:0] mva_lo,
    input  logic [DESC_W-1:0]     dacr,
    output l1_kind_e              kind,
    output logic [DOM_W-1:0]      dom,
    output logic [AP_W-1:0]       dom_acc,
    output walk_res_t             res
);

    logic unused_desc_bits;
    assign unused_desc_bits = ^{desc[L1_IDX_LSB-1:FINE_LSB], desc[DOM_LSB+DOM_W], desc[DOM_LSB-1:2]};

    assign kind    = l1_kind_e'(desc[1:0]);
    assign dom     = desc[DOM_LSB +: DOM_W];
    assign dom_acc = dacr[{dom, 1'b0} +: AP_W];

    always_comb begin
        res = '0;
        unique case (kind)
            L1_FAULT: begin
                res.fault = 1'b1;
                res.code  = FLT_SECTION;
            end
            L1_SECTION: begin
                res.paddr = {desc[DESC_W-1:L1_IDX_LSB], mva_lo};
                res.ap    = desc[L1_AP_LSB +: AP_W];
                res.code  = FLT_NONE;
            end
            default: begin
                // Table pointer: result comes from the second level.
                res.code  = FLT_NONE;
            end
        endcase
    end

endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
    import xlat_walker_pkg::*;
#(
    parameter bit TINY_EXT_EN = 1'b1
) (
    input  logic [DESC_W-1:0]    desc,
    input  logic [LARGE_LSB-1:0] mva_lo,
    input  logic                 fine,
    input  logic                 ext,
    output walk_res_t            res
);

    logic ext_ok;
    logic unused_desc_bits;
    assign unused_desc_bits = ^{desc[TINY_LSB-1:L2_AP_LSB+AP_W], desc[L2_AP_LSB-1:2]};

    generate
        if (TINY_EXT_EN) begin : g_ext
            assign ext_ok = ext;
        end else begin : g_no_ext
            logic unused_ext;
            assign unused_ext = ext;
            assign ext_ok     = 1'b0;
        end
    endgenerate

    l2_kind_e kind;
    assign kind = l2_kind_e'(desc[1:0]);

    always_comb begin
        res    = '0;
        res.ap = desc[L2_AP_LSB +: AP_W];
        unique case (kind)
            L2_FAULT: begin
                res.ap    = '0;
                res.fault = 1'b1;
                res.code  = FLT_PAGE;
            end
            L2_LARGE: res.paddr = {desc[DESC_W-1:LARGE_LSB], mva_lo};
            L2_SMALL: res.paddr = {desc[DESC_W-1:SMALL_LSB], mva_lo[SMALL_LSB-1:0]};
            L2_TINY: begin
                if (fine) begin
                    res.paddr = {desc[DESC_W-1:TINY_LSB], mva_lo[TINY_LSB-1:0]};
                end else if (ext_ok) begin
                    res.paddr = {desc[DESC_W-1:SMALL_LSB], mva_lo[SMALL_LSB-1:0]};
                end else begin
                    res.ap    = '0;
                    res.fault = 1'b1;
                    res.code  = FLT_PAGE;
                end
            end
            default: res.fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_walker_pkg::*;
#(
    parameter bit TINY_EXT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [VA_W-1:0]   pid_offset,
    input  logic [VA_W-1:0]   ttb,
    input  logic [DESC_W-1:0] dacr,
    input  logic              tiny_ext,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              done,
    output logic [VA_W-1:0]   paddr,
    output logic [AP_W-1:0]   ap,
    output logic              fault,
    output logic [CODE_W-1:0] fault_code,
    output logic [DOM_W-1:0]  walk_domain,
    output logic [AP_W-1:0]   dom_access
);

    walk_state_e state, state_nx;

    logic [VA_W-1:0]          mva_q;
    logic [VA_W-1:TTB_LSB]    ttb_q;
    logic [DESC_W-1:0]        dacr_q;
    logic                     ext_q;
    logic [VA_W-1:COARSE_LSB] tbl_q;
    logic                     fine_q;
    logic [DOM_W-1:0]         dom_q;
    logic [AP_W-1:0]          dacc_q;
    walk_res_t                res_q;

    logic [VA_W-1:0]  l1_addr;
    logic [VA_W-1:0]  l2_addr;
    l1_kind_e         l1_kind;
    logic [DOM_W-1:0] l1_dom;
    logic [AP_W-1:0]  l1_dacc;
    walk_res_t        l1_res;
    walk_res_t        l2_res;

    logic unused_ttb;
    assign unused_ttb = ^ttb[TTB_LSB-1:0];

    xlat_addr_gen u_addr (
        .mva_hi  (mva_q[VA_W-1:TINY_LSB]),
        .ttb_hi  (ttb_q),
        .tbl_hi  (tbl_q),
        .fine    (fine_q),
        .l1_addr (l1_addr),
        .l2_addr (l2_addr)
    );

    xlat_l1_decode u_l1 (
        .desc    (mem_rdata),
        .mva_lo  (mva_q[L1_IDX_LSB-1:0]),
        .dacr    (dacr_q),
        .kind    (l1_kind),
        .dom     (l1_dom),
        .dom_acc (l1_dacc),
        .res     (l1_res)
    );

    xlat_l2_decode #(.TINY_EXT_EN(TINY_EXT_EN)) u_l2 (
        .desc   (mem_rdata),
        .mva_lo (mva_q[LARGE_LSB-1:0]),
        .fine   (fine_q),
        .ext    (ext_q),
        .res    (l2_res)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_L1_READ;
            ST_L1_READ: begin
                if (mem_ack) begin
                    unique case (l1_kind)
                        L1_FAULT, L1_SECTION: state_nx = ST_DONE;
                        L1_COARSE, L1_FINE:   state_nx = ST_L2_READ;
                        default:              state_nx = ST_DONE;
                    endcase
                end
            end
            ST_L2_READ: if (mem_ack) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Walk context and result capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mva_q  <= '0;
            ttb_q  <= '0;
            dacr_q <= '0;
            ext_q  <= 1'b0;
            tbl_q  <= '0;
            fine_q <= 1'b0;
            dom_q  <= '0;
            dacc_q <= '0;
            res_q  <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                mva_q  <= vaddr + pid_offset;
                ttb_q  <= ttb[VA_W-1:TTB_LSB];
                dacr_q <= dacr;
                ext_q  <= tiny_ext;
            end
            if (state == ST_L1_READ && mem_ack) begin
                tbl_q  <= mem_rdata[DESC_W-1:COARSE_LSB];
                fine_q <= (l1_kind == L1_FINE);
                dom_q  <= l1_dom;
                dacc_q <= l1_dacc;
                res_q  <= l1_res;
            end
            if (state == ST_L2_READ && mem_ack) begin
                res_q  <= l2_res;
            end
        end
    end

    // Outputs.
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = l1_addr;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_L1_READ: mem_req = 1'b1;
            ST_L2_READ: begin
                mem_req  = 1'b1;
                mem_addr = l2_addr;
            end
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    assign paddr       = res_q.paddr;
    assign ap          = res_q.ap;
    assign fault       = res_q.fault;
    assign fault_code  = res_q.code;
    assign walk_domain = dom_q;
    assign dom_access  = dacc_q;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
    import xlat_walker_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [VA_W-1:0]   mem_addr,
    input logic              done,
    input logic              fault,
    input logic [CODE_W-1:0] fault_code
);

    logic [1:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_cnt <= '0;
        else if (done)    rd_cnt <= '0;
        else if (mem_ack) rd_cnt <= rd_cnt + 2'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req && !done));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_section_fault_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_code == FLT_SECTION) |-> (rd_cnt == 2'd1));

    assert_page_fault_two_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && fault_code == FLT_PAGE) |-> (rd_cnt == 2'd2));

    assert_fault_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code == FLT_SECTION || fault_code == FLT_PAGE));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mem_req));

    assert_no_req_at_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind xlat_walker xlat_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code)
);

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pid;
        logic [31:0] dacr;
        logic        ext;
        logic [31:0] l1;
        logic [31:0] l2;
        logic [31:0] l1a;
        logic [31:0] l2a;
        logic [1:0]  nrd;
        logic        flt;
        logic [3:0]  code;
        logic [31:0] pa;
        logic [1:0]  ap;
        logic [3:0]  dom;
        logic [1:0]  dacc;
    } vec_t;

    localparam logic [31:0] TTB = 32'h0010_3FFF;
    localparam int NV = 11;

    // va, pid, dacr, ext, l1, l2, l1a, l2a, nrd, flt, code, pa, ap, dom, dacc
    localparam vec_t VECS [NV] = '{
        // section R5
        '{32'h1234_5678, 32'h0, 32'h0000_000C, 1'b0, 32'h8000_0C22, 32'h0, 32'h0010_048C, 32'h0, 2'd1, 1'b0, 4'h0, 32'h8004_5678, 2'd3, 4'd1, 2'd3},
        // section fault after offset add R4 R2
        '{32'h0000_1000, 32'h0200_0000, 32'h4000_0000, 1'b0, 32'h0000_01E0, 32'h0, 32'h0010_0080, 32'h0, 2'd1, 1'b1, 4'h5, 32'h0, 2'd0, 4'd15, 2'd1},
        // coarse, small page R7 R9
        '{32'h0034_5ABC, 32'h0, 32'h0000_0030, 1'b0, 32'h0020_0441, 32'h1234_5022, 32'h0010_000C, 32'h0020_0514, 2'd2, 1'b0, 4'h0, 32'h1234_5ABC, 2'd2, 4'd2, 2'd3},
        // fine, tiny page R10
        '{32'h0567_89AB, 32'h0, 32'h0000_0000, 1'b0, 32'h0030_1063, 32'hABCD_E413, 32'h0010_0158, 32'h0030_1788, 2'd2, 1'b0, 4'h0, 32'hABCD_E5AB, 2'd1, 4'd3, 2'd0},
        // coarse, tiny, no extension R11
        '{32'h0034_5ABC, 32'h0, 32'h0000_0030, 1'b0, 32'h0020_0441, 32'h1234_5013, 32'h0010_000C, 32'h0020_0514, 2'd2, 1'b1, 4'h7, 32'h0, 2'd0, 4'd2, 2'd3},
        // coarse, tiny, extension R11
        '{32'h0034_5ABC, 32'h0, 32'h0000_0030, 1'b1, 32'h0020_0441, 32'h1234_5013, 32'h0010_000C, 32'h0020_0514, 2'd2, 1'b0, 4'h0, 32'h1234_5ABC, 2'd1, 4'd2, 2'd3},
        // fine, second-level fault R8
        '{32'h0567_89AB, 32'h0, 32'h0000_0000, 1'b0, 32'h0030_1063, 32'hABCD_E410, 32'h0010_0158, 32'h0030_1788, 2'd2, 1'b1, 4'h7, 32'h0, 2'd0, 4'd3, 2'd0},
        // coarse, large page R9
        '{32'h0034_5ABC, 32'h0, 32'h0000_0030, 1'b0, 32'h0020_0441, 32'hFEDC_0031, 32'h0010_000C, 32'h0020_0514, 2'd2, 1'b0, 4'h0, 32'hFEDC_5ABC, 2'd3, 4'd2, 2'd3},
        // offset add wraps R2, domain 0 R6
        '{32'hFFF0_0010, 32'h0020_0000, 32'h0000_0002, 1'b0, 32'h7FF0_0402, 32'h0, 32'h0010_0004, 32'h0, 2'd1, 1'b0, 4'h0, 32'h7FF0_0010, 2'd1, 4'd0, 2'd2},
        // fine, small page R9
        '{32'h0567_89AB, 32'h0, 32'h0000_0000, 1'b0, 32'h0030_1063, 32'h5555_5032, 32'h0010_0158, 32'h0030_1788, 2'd2, 1'b0, 4'h0, 32'h5555_59AB, 2'd3, 4'd3, 2'd0},
        // fine, tiny, extension set: still 1 KB R10
        '{32'h0567_89AB, 32'h0, 32'h0000_0000, 1'b1, 32'h0030_1063, 32'hABCD_E413, 32'h0010_0158, 32'h0030_1788, 2'd2, 1'b0, 4'h0, 32'hABCD_E5AB, 2'd1, 4'd3, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0;
    logic [31:0] pid_offset = '0;
    logic [31:0] ttb = '0;
    logic [31:0] dacr = '0;
    logic        tiny_ext = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        done;
    logic [31:0] paddr;
    logic [1:0]  ap;
    logic        fault;
    logic [3:0]  fault_code;
    logic [3:0]  walk_domain;
    logic [1:0]  dom_access;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xlat_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .pid_offset(pid_offset), .ttb(ttb), .dacr(dacr), .tiny_ext(tiny_ext),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .ap(ap),
        .fault(fault), .fault_code(fault_code), .walk_domain(walk_domain),
        .dom_access(dom_access)
    );

    // Memory model: first read of a walk returns cur_l1, second cur_l2.
    logic [31:0] cur_l1 = '0;
    logic [31:0] cur_l2 = '0;
    int          lat = 0;
    logic        clr = 1'b0;
    int          wcnt;
    logic [1:0]  nrd;
    logic [31:0] l1a_seen;
    logic [31:0] l2a_seen;

    always @(posedge clk) begin
        if (!rst_n || clr) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
            nrd       <= '0;
            l1a_seen  <= '0;
            l2a_seen  <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= (nrd == 2'd0) ? cur_l1 : cur_l2;
                if (nrd == 2'd0) l1a_seen <= mem_addr;
                else             l2a_seen <= mem_addr;
                nrd <= nrd + 2'd1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input vec_t v, input int l);
        @(negedge clk);
        vaddr = v.va; pid_offset = v.pid; dacr = v.dacr; tiny_ext = v.ext;
        ttb = TTB; cur_l1 = v.l1; cur_l2 = v.l2; lat = l; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R13 done seen", {31'b0, done}, 32'd1);
    endtask

    task automatic check_vec(input vec_t v);
        chk("R2,R3 first read address", l1a_seen, v.l1a);
        chk("R4,R12 read count", {30'b0, nrd}, {30'b0, v.nrd});
        if (v.nrd == 2'd2) chk("R7 second read address", l2a_seen, v.l2a);
        chk("R4,R8,R11 fault flag", {31'b0, fault}, {31'b0, v.flt});
        if (v.flt) begin
            chk("R4,R8,R11 fault code", {28'b0, fault_code}, {28'b0, v.code});
        end else begin
            chk("R5,R9,R10,R11 physical address", paddr, v.pa);
            chk("R5,R9 access bits", {30'b0, ap}, {30'b0, v.ap});
        end
        chk("R6 domain", {28'b0, walk_domain}, {28'b0, v.dom});
        chk("R6 domain access", {30'b0, dom_access}, {30'b0, v.dacc});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        chk("R1 fault after reset", {31'b0, fault}, 32'd0);
        chk("R1 paddr after reset", paddr, 32'd0);

        // Table walk over all vectors with varying acknowledge latency.
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i], i % 4);
            wait_done();
            check_vec(VECS[i]);
        end

        // R12: request and address held through a long wait.
        launch(VECS[2], 6);
        held = mem_addr;
        for (int k = 0; k < 4; k++) begin
            chk("R12 request held", {31'b0, mem_req}, 32'd1);
            chk("R12 address stable", mem_addr, held);
            @(negedge clk);
        end
        wait_done();
        check_vec(VECS[2]);

        // R13 / R2: start and input changes during a walk are ignored.
        launch(VECS[0], 5);
        vaddr = 32'h0; ttb = 32'h0; pid_offset = 32'h0100_0000; start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_vec(VECS[0]);
        @(negedge clk);
        chk("R13 done lasts one cycle", {31'b0, done}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            chk("R13 no walk after done", {31'b0, mem_req}, 32'd0);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule